// File: doc/BRIEF.md
# Instruction-Armed Watchdog Timer

This block is the watchdog of a small microcontroller core. The instruction decoder gives it two single-cycle strobes. One is the watchdog command. The other is the halt-enable command. The core also supplies its HALT and STOP mode indicators. A static option bit selects a permanently enabled watchdog. After reset the timer is disabled. The first watchdog command arms it, and each later command restarts the timeout window. Once armed, no instruction can stop it. If software does not refresh the timer within the window, the block requests a system reset. That request lasts for the power-on reset length plus 18 extra clocks.

While armed and idle, the counter advances on every clock. With only software enabling, the counter freezes during STOP. It also freezes during HALT unless halt-enable was given. With the option bit set, the timer arms itself on the first clock after reset and counts through HALT and STOP. A paused counter keeps its value and resumes from it. The block also outputs the flag values that the watchdog instruction writes.

The controller is a three-state machine: DISABLED, ARMED and RESETTING. There are four transitions. DISABLED goes to ARMED on a watchdog command or when the option bit is set. ARMED goes to RESETTING on a timeout. RESETTING goes to DISABLED when the pulse ends. The system reset returns the machine to DISABLED from any state.

Top module: `wdg_ctrl`

## Requirements
- R1: While disabled, a watchdog command arms the timer with its counter at zero. From the next clock on, rst_req stays low for at least TIMEOUT clock edges.
- R2: While armed, a watchdog command restarts the count from zero. This holds on the very edge where the count would otherwise expire.
- R3: While armed, no input other than the system reset (rst_n low) returns the timer to the disabled state before it times out. This includes halt-enable, HALT and STOP.
- R4: If the counter runs for TIMEOUT edges with no watchdog command, rst_req goes high at the last of those edges.
- R5: rst_req stays high for exactly POR_LEN + PULSE_EXTRA cycles. The timer is then disabled and halt-enable is cleared. rst_req is low after the system reset.
- R6: A halt-enable command given while armed lets the counter keep running during HALT. It does not clear the count.
- R7: A halt-enable command given while disabled has no effect. A later HALT still pauses the timer once it is armed.
- R8: A software-armed timer holds its count while STOP is high. Without halt-enable, it also holds its count while HALT is high. In both cases it resumes from the held value.
- R9: With perm_en set, the timer arms on the first edge after reset and counts through HALT and STOP. After a reset pulse it arms again.
- R10: The flag outputs are fixed: flag_wr follows wd_cmd in the same cycle, flag_z is 1, and flag_s and flag_v are 0.
- R11: Watchdog and halt-enable commands given during the reset pulse neither shorten nor lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| wd_cmd | input | 1 | One-cycle watchdog command strobe |
| wdh_cmd | input | 1 | One-cycle halt-enable command strobe |
| perm_en | input | 1 | Static permanent-enable option bit |
| halt_mode | input | 1 | Core is in HALT |
| stop_mode | input | 1 | Core is in STOP |
| rst_req | output | 1 | Timeout reset request |
| flag_wr | output | 1 | Flag write strobe for the watchdog instruction |
| flag_z | output | 1 | Zero flag value written |
| flag_s | output | 1 | Sign flag value written |
| flag_v | output | 1 | Overflow flag value written |

## Verification
The bench targets a set of specific corner cases. One is a refresh on the exact expiry edge; an off-by-one compare would fire one window late or let the reset slip through. Another is halt-enable given before arming; a design that latched it would keep counting through HALT. A third is STOP with halt-enable set; a design that treated the two modes alike would time out while stopped. The bench also issues commands during the reset pulse, and measures the pulse length and the re-arming with perm_en set. A wrong pulse counter or exit transition would show up there as a bad pulse length or a timer that never returns.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_t;
endpackage

// File: rtl/wdg_timebase.sv
module wdg_timebase #(
    parameter int TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] TOP = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;
    logic          at_top;

    assign at_top = (cnt == TOP);
    assign expire = run && !clear && at_top;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (run)
            cnt <= at_top ? '0 : cnt + 1'b1;
    end

    // R8
    paused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(cnt));

    // R2
    refresh_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
endmodule

// File: rtl/wdg_rstgen.sv
module wdg_rstgen #(
    parameter int PULSE = 82
) (
    input  logic clk,
    input  logic rst_n,
    input  logic firing,
    output logic pulse_done
);
    localparam int PW = $clog2(PULSE + 1);
    localparam logic [PW-1:0] LAST = PW'(PULSE - 1);

    logic [PW-1:0] pcnt;

    assign pulse_done = firing && (pcnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (!firing)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

    // R5
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (firing && !pulse_done) |=> firing);

    // R5
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_done |=> !firing);
endmodule

// File: rtl/wdg_fsm.sv
module wdg_fsm
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wd_cmd,
    input  logic wdh_cmd,
    input  logic perm_en,
    input  logic expire,
    input  logic pulse_done,
    output logic armed,
    output logic firing,
    output logic wdh_en
);
    wd_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= WD_OFF;
            wdh_en <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == WD_FIRE)
                wdh_en <= 1'b0;
            else if (state == WD_ARMED && wdh_cmd)
                wdh_en <= 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WD_OFF:   if (wd_cmd || perm_en) state_nx = WD_ARMED;
            WD_ARMED: if (expire)            state_nx = WD_FIRE;
            WD_FIRE:  if (pulse_done)        state_nx = WD_OFF;
            default:                         state_nx = WD_OFF;
        endcase
    end

    always_comb begin
        armed  = (state == WD_ARMED);
        firing = (state == WD_FIRE);
    end

    // R3
    stay_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_ARMED && !expire) |=> (state == WD_ARMED));

    // R7
    no_early_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_OFF) |-> !wdh_en);

    // R1
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_OFF && wd_cmd) |=> (state == WD_ARMED));
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl #(
    parameter int TIMEOUT     = 4096,
    parameter int POR_LEN     = 64,
    parameter int PULSE_EXTRA = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_cmd,
    input  logic wdh_cmd,
    input  logic perm_en,
    input  logic halt_mode,
    input  logic stop_mode,
    output logic rst_req,
    output logic flag_wr,
    output logic flag_z,
    output logic flag_s,
    output logic flag_v
);
    localparam int PULSE = POR_LEN + PULSE_EXTRA;

    logic armed, firing, wdh_en, expire, pulse_done;
    logic halt_block, stop_block, run, clear;

    assign halt_block = halt_mode && !(wdh_en || perm_en);
    assign stop_block = stop_mode && !perm_en;
    assign run        = armed && !halt_block && !stop_block;
    assign clear      = !armed || wd_cmd;

    wdg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wd_cmd     (wd_cmd),
        .wdh_cmd    (wdh_cmd),
        .perm_en    (perm_en),
        .expire     (expire),
        .pulse_done (pulse_done),
        .armed      (armed),
        .firing     (firing),
        .wdh_en     (wdh_en)
    );

    wdg_timebase #(.TIMEOUT(TIMEOUT)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .run    (run),
        .expire (expire)
    );

    wdg_rstgen #(.PULSE(PULSE)) u_rg (
        .clk        (clk),
        .rst_n      (rst_n),
        .firing     (firing),
        .pulse_done (pulse_done)
    );

    assign rst_req = firing;
    assign flag_wr = wd_cmd;
    assign flag_z  = 1'b1;
    assign flag_s  = 1'b0;
    assign flag_v  = 1'b0;

    // R9
    perm_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (perm_en && !armed && !firing) |=> armed);

    // R10
    flag_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_cmd |-> (flag_wr && flag_z && !flag_s && !flag_v));
endmodule

// File: tb/wdg_ctrl_test.sv
module wdg_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int TO    = 24;
    localparam int POR   = 6;
    localparam int EXTRA = 18;
    localparam int PULSE = POR + EXTRA;

    logic clk = 1'b0;
    logic rst_n, wd, wdh, perm, halt, stop;
    logic rst_req, flag_wr, flag_z, flag_s, flag_v;

    int n_chk  = 0;
    int n_fail = 0;
    int m_state, m_cnt, m_pc;
    bit m_wdh;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_ctrl #(.TIMEOUT(TO), .POR_LEN(POR), .PULSE_EXTRA(EXTRA)) uut (
        .clk(clk), .rst_n(rst_n), .wd_cmd(wd), .wdh_cmd(wdh), .perm_en(perm),
        .halt_mode(halt), .stop_mode(stop), .rst_req(rst_req),
        .flag_wr(flag_wr), .flag_z(flag_z), .flag_s(flag_s), .flag_v(flag_v)
    );

    task automatic check(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_edge();
        bit run;
        unique case (m_state)
            0: if (wd || perm) begin m_state = 1; m_cnt = 0; end
            1: begin
                run = !(halt && !(m_wdh || perm)) && !(stop && !perm);
                if (wdh) m_wdh = 1;
                if (wd) m_cnt = 0;
                else if (run) begin
                    if (m_cnt == TO-1) begin m_state = 2; m_pc = 0; m_cnt = 0; end
                    else m_cnt++;
                end
            end
            default: begin
                m_wdh = 0;
                if (m_pc == PULSE-1) m_state = 0;
                else m_pc++;
            end
        endcase
    endfunction

    // called at a falling edge; drives, checks flags, clocks, checks rst_req
    task automatic step(string tag, bit w, bit h, bit hl, bit st);
        wd = w; wdh = h; halt = hl; stop = st;
        #1;
        check("R10 flag_wr", flag_wr, w);
        check("R10 flag_z", flag_z, 1'b1);
        check("R10 flag_s/v", flag_s | flag_v, 1'b0);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, rst_req, m_state == 2);
    endtask

    task automatic do_reset(bit p);
        perm = p; wd = 0; wdh = 0; halt = 0; stop = 0;
        rst_n = 0;
        m_state = 0; m_cnt = 0; m_pc = 0; m_wdh = 0;
        repeat (2) @(negedge clk);
        check("R5 reset state", rst_req, 1'b0);
        rst_n = 1;
        @(negedge clk);
        model_edge();
        check("R9 post-reset", rst_req, 1'b0);
    endtask

    task automatic idle(string tag, int n, bit hl, bit st);
        for (int i = 0; i < n; i++) step(tag, 0, 0, hl, st);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int hi;
        void'($urandom(32'd1234));
        rst_n = 0; perm = 0; wd = 0; wdh = 0; halt = 0; stop = 0;
        @(negedge clk);

        // R1 / R4: arm, expire exactly TO edges later
        do_reset(0);
        idle("R1 idle while disabled", 3 * TO, 0, 0);
        step("R1 arm", 1, 0, 0, 0);
        idle("R4 window", TO - 1, 0, 0);
        step("R4 expiry edge", 0, 0, 0, 0);
        check("R4 rst_req high", rst_req, 1'b1);
        // R5 pulse length
        hi = 1;
        while (rst_req && hi < 4 * PULSE) begin step("R5 pulse", 0, 0, 0, 0); if (rst_req) hi++; end
        n_chk++;
        if (hi != PULSE) begin n_fail++; $display("FAIL R5 pulse length: actual %0d expected %0d", hi, PULSE); end
        idle("R5 disabled after pulse", 2 * TO, 0, 0);

        // R2: refresh on exact expiry edge
        step("R1 rearm", 1, 0, 0, 0);
        for (int k = 0; k < 5; k++) begin
            idle("R2 window", TO - 1, 0, 0);
            step("R2 refresh at expiry edge", 1, 0, 0, 0);
        end
        idle("R2 final", TO + 2, 0, 0);

        // R7 / R8: halt-enable before arming is ignored, HALT pauses
        do_reset(0);
        step("R7 early wdh", 0, 1, 0, 0);
        step("R1 arm", 1, 0, 0, 0);
        idle("R8 counting", TO / 2, 0, 0);
        idle("R7 halt paused", 3 * TO, 1, 0);
        idle("R8 resume", TO / 2 + 2, 0, 0);
        idle("R8 to pulse", PULSE + 2, 0, 0);

        // R6: halt-enable while armed, counter keeps running in HALT
        do_reset(0);
        step("R1 arm", 1, 0, 0, 0);
        idle("R6 run", 5, 0, 0);
        step("R6 wdh", 0, 1, 0, 0);
        idle("R6 halt counting", TO + PULSE, 1, 0);
        // R8: STOP still pauses even with halt-enable
        step("R1 arm", 1, 0, 0, 0);
        step("R6 wdh", 0, 1, 0, 0);
        idle("R8 stop paused", 3 * TO, 0, 1);
        idle("R3 run out", TO + 2, 0, 0);

        // R9: permanent option counts through HALT and STOP, rearms
        do_reset(1);
        idle("R9 stop", TO + 3, 0, 1);
        idle("R9 halt", 2 * TO + PULSE, 1, 0);
        // R11: commands during pulse
        for (int i = 0; i < PULSE + 4; i++) step("R11 cmd in pulse", rst_req, rst_req, 0, 0);

        // R3 / random: mixed stimulus against the model
        for (int ph = 0; ph < 6; ph++) begin
            do_reset(ph[0]);
            for (int i = 0; i < 800; i++)
                step("R3 random", ($urandom % 30) == 0, ($urandom % 40) == 0,
                     ($urandom % 4) == 0, ($urandom % 6) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule